// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two two's-complement operands of N bits each and returns a signed product of 2N bits. It favours area over speed. A single adder/subtractor of 2N bits is reused over N clock cycles, and one multiplier bit is consumed per cycle. The multiplicand is sign-extended to the full product width when it is loaded. It is then shifted left by one place each step, so every partial product that reaches the accumulator is already sign-correct at 2N bits. Steps for the low N-1 multiplier bits add the shifted multiplicand when the bit is one. The step for the multiplier's sign bit subtracts it instead, because that bit has weight -2^(N-1).

The user pulses `start_i` while the block is idle, with the operands presented on `a_i` and `b_i` in that cycle. `busy_o` then stays high for exactly N cycles, and start requests made during that time are ignored. On the cycle after the last step, `done_o` pulses once. From that cycle on, `product_o` holds the result until the next accepted start.

Top module: `shift_add_smul`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and product_o is 0.
- R2: For any N-bit signed a_i and b_i captured at an accepted start, the product_o value shown while done_o is 1 equals the 2N-bit two's-complement value of a_i times b_i.
- R3: The operands -2^(N-1) and -2^(N-1) produce +2^(2N-2). This is 0x40000000 at N=16 and is read as positive in the 2N-bit result.
- R4: A start_i high while busy_o is 0 is accepted at that clock edge. busy_o is then 1 for exactly N consecutive cycles, and done_o rises on the same edge at which busy_o falls.
- R5: done_o is 1 for exactly one cycle per operation.
- R6: A start_i high while busy_o is 1 is ignored, whatever values a_i and b_i carry at the time. The running operation keeps its operands and its timing.
- R7: While idle, product_o stays unchanged until the next accepted start, and changes on a_i and b_i have no effect on it.
- R8: A step whose multiplier bit is 0 leaves the product register unchanged. With b_i = 0, product_o reads 0 in every busy cycle.
- R9: The step for the multiplier's sign bit subtracts the shifted multiplicand. A negative b_i, including -1 and -2^(N-1), gives the correctly signed product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply; accepted only while idle |
| a_i | input | N | Signed multiplicand |
| b_i | input | N | Signed multiplier |
| busy_o | output | 1 | High during the N step cycles |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2N | Signed product register |

## Verification
At N=4, all 256 operand pairs are tried. This separates sign-extension faults from faults in the subtract step, because each mix of operand signs appears. At N=16, directed corner cases are applied: both operands most negative, multiplier -1, multiplier most negative, multiplier zero and multiplicand zero. These isolate the final subtraction, the top-bit weight and the skipped-add path. Random vectors follow and cover mixed bit densities. Separate scenarios pulse start in mid-operation with new operands, and change the operands while idle. These show whether the operand registers and the product register really ignore such requests.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  import smul_pkg::*;

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  smul_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == LAST_IDX);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + CW'(1);
        if (last_o) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/smul_opreg.sv
module smul_opreg #(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] mcand_o,
  output logic           bit_o
);
  localparam int P = 2 * N;

  logic [P-1:0] a_ext;
  logic [P-1:0] mcand_q;
  logic [N-1:0] mplier_q;

  // sign-extension stage on the multiplicand path
  for (genvar i = 0; i < P; i++) begin : g_sext
    if (i < N) begin : g_lo
      assign a_ext[i] = a_i[i];
    end else begin : g_hi
      assign a_ext[i] = a_i[N-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load_i) begin
      mcand_q  <= a_ext;
      mplier_q <= b_i;
    end else if (step_i) begin
      mcand_q  <= {mcand_q[P-2:0], 1'b0};
      mplier_q <= {1'b0, mplier_q[N-1:1]};
    end
  end

  assign mcand_o = mcand_q;
  assign bit_o   = mplier_q[0];
endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           sub_i,
  input  logic           bit_i,
  input  logic [2*N-1:0] mcand_i,
  output logic [2*N-1:0] acc_o
);
  localparam int P = 2 * N;

  logic [P-1:0] acc_q;
  logic [P-1:0] addend;
  logic [P-1:0] operand;
  logic [P-1:0] sum;

  // zero partial product when the bit is clear; ~0 + 1 wraps to no change
  assign addend  = bit_i ? mcand_i : '0;
  assign operand = sub_i ? ~addend : addend;
  assign sum     = acc_q + operand + {{(P-1){1'b0}}, sub_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (load_i)  acc_q <= '0;
    else if (step_i)  acc_q <= sum;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/shift_add_smul.sv
module shift_add_smul #(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  logic           load;
  logic           step;
  logic           last;
  logic           opr_bit;
  logic [2*N-1:0] mcand;

  smul_ctrl #(.N(N)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  smul_opreg #(.N(N)) i_opreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .a_i     (a_i),
    .b_i     (b_i),
    .mcand_o (mcand),
    .bit_o   (opr_bit)
  );

  smul_accum #(.N(N)) i_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .sub_i   (last),
    .bit_i   (opr_bit),
    .mcand_i (mcand),
    .acc_o   (product_o)
  );
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
  parameter int N = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*N-1:0] product_o,
  input logic           step_bit_i
);
  localparam int P  = 2 * N;
  localparam int KW = $clog2(N + 1) + 1;

  logic [KW-1:0] busy_cnt_q;
  logic [P-1:0]  exp_q;
  logic [P-1:0]  a_ext;
  logic [P-1:0]  b_ext;

  assign a_ext = {{N{a_i[N-1]}}, a_i};
  assign b_ext = {{N{b_i[N-1]}}, b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
      exp_q      <= '0;
    end else begin
      busy_cnt_q <= busy_o ? busy_cnt_q + KW'(1) : '0;
      if (start_i && !busy_o) exp_q <= a_ext * b_ext;
    end
  end

  assert_product_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == exp_q);

  assert_start_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt_q < KW'(N));

  assert_done_timing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt_q == KW'(N)) && !busy_o);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));

  assert_zero_bit_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step_bit_i) |=> $stable(product_o));
endmodule

bind shift_add_smul smul_checker #(.N(N)) i_smul_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .product_o  (product_o),
  .step_bit_i (opr_bit)
);

// File: tb/test_shift_add_smul.sv
module test_shift_add_smul;
  localparam int N  = 16;
  localparam int M  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            start16 = 1'b0;
  logic [N-1:0]    a16 = '0, b16 = '0;
  logic            busy16, done16;
  logic [2*N-1:0]  prod16;

  logic            start4 = 1'b0;
  logic [M-1:0]    a4 = '0, b4 = '0;
  logic            busy4, done4;
  logic [2*M-1:0]  prod4;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  shift_add_smul #(.N(N)) i_shift_add_smul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start16), .a_i(a16), .b_i(b16),
    .busy_o(busy16), .done_o(done16), .product_o(prod16));

  shift_add_smul #(.N(M)) i_shift_add_smul_n4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start4), .a_i(a4), .b_i(b4),
    .busy_o(busy4), .done_o(done4), .product_o(prod4));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one N=16 operation; optionally pulses start with other operands mid-run (R6)
  task automatic run16(input logic [N-1:0] a, input logic [N-1:0] b, input string req,
                       input bit poke, input bit zero_watch);
    longint exp;
    int busy_cnt;
    exp = longint'($signed(a)) * longint'($signed(b));
    @(negedge clk);
    a16 = a; b16 = b; start16 = 1'b1;
    @(negedge clk);
    start16 = 1'b0;
    busy_cnt = 0;
    while (busy16 && busy_cnt < 4 * N) begin
      busy_cnt++;
      if (zero_watch) check(prod16 == '0, "R8 zero multiplier", longint'(prod16), 0);
      if (poke && busy_cnt == 3) begin
        a16 = ~a; b16 = ~b; start16 = 1'b1;
      end else begin
        start16 = 1'b0;
      end
      @(negedge clk);
    end
    start16 = 1'b0;
    check(busy_cnt == N, "R4 busy length", busy_cnt, N);
    check(done16 == 1'b1, "R4 done with busy fall", longint'(done16), 1);
    check(longint'($signed(prod16)) == exp, req, longint'($signed(prod16)), exp);
    @(negedge clk);
    check(done16 == 1'b0, "R5 done single cycle", longint'(done16), 0);
    check(longint'($signed(prod16)) == exp, "R7 product held", longint'($signed(prod16)), exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(busy16 == 1'b0, "R1 busy after reset", longint'(busy16), 0);
    check(done16 == 1'b0, "R1 done after reset", longint'(done16), 0);
    check(prod16 == '0, "R1 product after reset", longint'(prod16), 0);
  endtask

  task automatic test_corners();
    run16(16'h8000, 16'h8000, "R3 most negative squared", 1'b0, 1'b0);
    check(prod16 == 32'h4000_0000, "R3 exact bits", longint'(prod16), 64'h4000_0000);
    run16(16'd1, 16'hFFFF, "R9 multiplier -1", 1'b0, 1'b0);
    run16(16'd1, 16'h8000, "R9 multiplier most negative", 1'b0, 1'b0);
    run16(16'h7FFF, 16'h8000, "R9 max times min", 1'b0, 1'b0);
    run16(16'hFFFD, 16'd5, "R2 -3 times 5", 1'b0, 1'b0);
    run16(16'd0, 16'h8001, "R2 zero multiplicand", 1'b0, 1'b0);
    run16(16'h7FFF, 16'h7FFF, "R2 max squared", 1'b0, 1'b0);
  endtask

  task automatic test_zero_multiplier();
    run16(16'h5A5A, 16'd0, "R8 zero multiplier result", 1'b0, 1'b1);
  endtask

  task automatic test_ignored_start();
    run16(16'h1234, 16'hF00D, "R6 start during busy ignored", 1'b1, 1'b0);
  endtask

  task automatic test_idle_hold();
    logic [2*N-1:0] held;
    run16(16'h0ABC, 16'hFF01, "R2 before hold", 1'b0, 1'b0);
    held = prod16;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a16 = a16 + 16'h1111; b16 = b16 ^ 16'h0F0F;
    end
    check(prod16 == held, "R7 idle input change", longint'(prod16), longint'(held));
    check(busy16 == 1'b0, "R7 stays idle", longint'(busy16), 0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 200; i++) begin
      run16(16'($urandom), 16'($urandom), "R2 random", 1'b0, 1'b0);
    end
  endtask

  task automatic test_exhaustive4();
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        int exp;
        int cyc;
        exp = int'($signed(4'(ia))) * int'($signed(4'(ib)));
        @(negedge clk);
        a4 = 4'(ia); b4 = 4'(ib); start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        cyc = 0;
        while (!done4 && cyc < 20) begin
          @(negedge clk);
          cyc++;
        end
        check(cyc == M, "R4 n4 latency", cyc, M);
        check(int'($signed(prod4)) == exp, "R2 n4 exhaustive",
              longint'($signed(prod4)), longint'(exp));
      end
    end
  endtask

  initial begin
    #40 rst_n = 1'b1;
    test_reset();
    test_corners();
    test_zero_multiplier();
    test_ignored_start();
    test_idle_hold();
    test_random();
    test_exhaustive4();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule